// File: doc/BRIEF.md
# Omega-Flip Two-Stage Permuter

This block rearranges the bits of a word of parameterised power-of-two width (64 by default). Inside it sit four permutation stages in a fixed chain: two omega stages, then two flip stages. An omega stage first applies a perfect shuffle and then a column of two-bit straight/swap cells. A flip stage applies the cell column first and then the inverse shuffle. Every stage can also be told to pass its input through unchanged.

Each operation turns on exactly two adjacent stages, and a two-bit mode code chooses which two. The lower half of the control word sets the swap cells of the first active stage. The upper half sets the second active stage. The two remaining stages pass their data straight through. Software can realise any permutation of the word by chaining log2(width) operations, with each result fed back as the next source. This block does not work out the control words. It only applies them.

The permutation logic is combinational. The result is captured in an output register when the input valid is high. The output valid is a pulse that comes one cycle after each accepted input.

Top module: `ofp_permuter`

## Requirements
- R1: After synchronous active-low reset, out_valid is 0 and dst is all zeros.
- R2: A result appears on dst with out_valid high exactly one cycle after in_valid is high. When in_valid is low, dst keeps its value and out_valid is 0 in the next cycle, whatever src, ctrl and mode carry.
- R3: Mode code 3 is bypass: dst equals src and ctrl has no effect.
- R4: Mode code 0 with an all-zero ctrl gives two plain perfect shuffles: the bit at index i moves to index rotl(rotl(i)), where rotl rotates the log2(width)-bit index left by one.
- R5: An omega stage moves bit i to index rotl(i). It then swaps the bits at indices 2k and 2k+1 when its control bit k is 1.
- R6: A flip stage swaps the bits at indices 2k and 2k+1 when its control bit k is 1. It then moves bit j to index rotr(j), which is the inverse shuffle.
- R7: Mode 0 activates omega then omega. Mode 1 activates the second omega stage then the first flip stage. Mode 2 activates flip then flip. In every mode, ctrl bits [W/2-1:0] configure the first active stage and ctrl bits [W-1:W/2] configure the second.
- R8: The number of ones in dst always equals the number of ones in the accepted src.
- R9: Mode 1 with an all-zero ctrl is the identity, because the shuffle and the inverse shuffle cancel.
- R10: Mode 2 with an all-zero ctrl gives two inverse shuffles: bit i moves to rotr(rotr(i)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept src, ctrl and mode this cycle |
| src | input | W | Word to be permuted |
| ctrl | input | W | Swap controls: low half for the first active stage, high half for the second |
| mode | input | 2 | Active stage pair: 0 omega+omega, 1 omega+flip, 2 flip+flip, 3 bypass |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| dst | output | W | Registered permuted word |

## Verification
Some properties are checked on every cycle: the one-cycle valid latency, dst holding while idle, bypass returning the source unchanged, the ones count being preserved, and exactly two stages being active in every non-bypass mode. Only the bench scenarios can show where each bit actually lands. They compare dst against an independent shuffle/exchange model in all three two-stage modes, including the zero-control corner cases (double shuffle, cancelling shuffle pair, double inverse shuffle), and they confirm that each half of ctrl reaches the correct stage.

// File: rtl/ofp_pkg.sv
// Shared types for the omega-flip permuter.
package ofp_pkg;
    // Active stage pair selection
    typedef enum logic [1:0] {
        MODE_OO     = 2'd0,
        MODE_OF     = 2'd1,
        MODE_FF     = 2'd2,
        MODE_BYPASS = 2'd3
    } mode_e;
endpackage

// File: rtl/ofp_stage.sv
// One permutation stage. IS_OMEGA=1: perfect shuffle, then pairwise
// straight/swap cells on adjacent pairs. IS_OMEGA=0: cells, then inverse
// shuffle. pass=1 forwards din unchanged. Assumes N is a power of two, N >= 4.
module ofp_stage #(
    parameter int N        = 64,
    parameter bit IS_OMEGA = 1'b1
) (
    input  logic [N-1:0]   din,
    input  logic [N/2-1:0] swap,
    input  logic           pass,
    output logic [N-1:0]   dout
);
    localparam int L    = $clog2(N);
    localparam int HALF = N / 2;

    logic [N-1:0] cell_in;
    logic [N-1:0] cell_out;
    logic [N-1:0] perm;

    // Column of straight/swap cells on adjacent pairs
    for (genvar k = 0; k < HALF; k++) begin : g_cell
        assign cell_out[2*k]   = swap[k] ? cell_in[2*k+1] : cell_in[2*k];
        assign cell_out[2*k+1] = swap[k] ? cell_in[2*k]   : cell_in[2*k+1];
    end

    if (IS_OMEGA) begin : g_omega
        // Shuffle: output j takes input rotr(j)
        for (genvar j = 0; j < N; j++) begin : g_shuf
            localparam int FROM = (j >> 1) | ((j & 1) << (L - 1));
            assign cell_in[j] = din[FROM];
        end
        assign perm = cell_out;
    end else begin : g_flip
        assign cell_in = din;
        // Inverse shuffle: output j takes cell output rotl(j)
        for (genvar j = 0; j < N; j++) begin : g_unshuf
            localparam int FROM = ((j << 1) & (N - 1)) | (j >> (L - 1));
            assign perm[j] = cell_out[FROM];
        end
    end

    // Pass-through selection
    assign dout = pass ? din : perm;
endmodule

// File: rtl/ofp_decode.sv
// Mode decoder: picks the two active stages and routes the low control
// half to the first active stage and the high half to the second.
module ofp_decode
    import ofp_pkg::*;
#(
    parameter int N = 64
) (
    input  mode_e                   mode,
    input  logic [N-1:0]            ctrl,
    output logic [3:0]              pass_vec,
    output logic [3:0][N/2-1:0]     stage_swap
);
    localparam int HALF = N / 2;

    logic [HALF-1:0] lo_half;
    logic [HALF-1:0] hi_half;

    assign lo_half = ctrl[HALF-1:0];
    assign hi_half = ctrl[N-1:HALF];

    // Stage enables and control routing per mode
    always_comb begin
        pass_vec   = 4'b1111;
        stage_swap = '0;
        case (mode)
            MODE_OO: begin
                pass_vec      = 4'b1100;
                stage_swap[0] = lo_half;
                stage_swap[1] = hi_half;
            end
            MODE_OF: begin
                pass_vec      = 4'b1001;
                stage_swap[1] = lo_half;
                stage_swap[2] = hi_half;
            end
            MODE_FF: begin
                pass_vec      = 4'b0011;
                stage_swap[2] = lo_half;
                stage_swap[3] = hi_half;
            end
            default: begin
                pass_vec = 4'b1111;
            end
        endcase
    end
endmodule

// File: rtl/ofp_permuter.sv
// Omega-flip permuter top: four stages (omega, omega, flip, flip), two of
// which are active per operation, with a registered result and a valid
// pulse one cycle after each accepted input.
module ofp_permuter
    import ofp_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] src,
    input  logic [W-1:0] ctrl,
    input  logic [1:0]   mode,
    output logic         out_valid,
    output logic [W-1:0] dst
);
    localparam int STAGES = 4;
    localparam int HALF   = W / 2;

    mode_e                       mode_q;
    logic [STAGES-1:0]           pass_vec;
    logic [STAGES-1:0][HALF-1:0] stage_swap;
    logic [STAGES:0][W-1:0]      link;

    assign mode_q  = mode_e'(mode);
    assign link[0] = src;

    ofp_decode #(.N(W)) u_decode (
        .mode       (mode_q),
        .ctrl       (ctrl),
        .pass_vec   (pass_vec),
        .stage_swap (stage_swap)
    );

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        ofp_stage #(.N(W), .IS_OMEGA(s < 2)) u_stage (
            .din  (link[s]),
            .swap (stage_swap[s]),
            .pass (pass_vec[s]),
            .dout (link[s+1])
        );
    end

    // Output register and valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dst       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst <= link[STAGES];
            end
        end
    end

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(dst)));
    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd3) |=> (dst == $past(src)));
    p_ones_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($countones(dst) == $past($countones(src))));
    p_two_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd3) |-> ($countones(pass_vec) == 2));
endmodule

// File: tb/ofp_permuter_bench.sv
module ofp_permuter_bench;
    localparam int W = 64;
    localparam int H = W / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] src = '0;
    logic [W-1:0] ctrl = '0;
    logic [1:0]   mode = 2'd0;
    logic         out_valid;
    logic [W-1:0] dst;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ofp_permuter #(.W(W)) u_ofp_permuter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
        .ctrl(ctrl), .mode(mode), .out_valid(out_valid), .dst(dst)
    );

    // Reference model
    function automatic int up_idx(int i);
        return (i < H) ? 2 * i : 2 * i - W + 1;
    endfunction

    function automatic logic [W-1:0] do_swaps(logic [W-1:0] x, logic [H-1:0] c);
        logic [W-1:0] y = x;
        for (int k = 0; k < H; k++) begin
            if (c[k]) begin
                y[2*k]   = x[2*k+1];
                y[2*k+1] = x[2*k];
            end
        end
        return y;
    endfunction

    function automatic logic [W-1:0] ref_omega(logic [W-1:0] x, logic [H-1:0] c);
        logic [W-1:0] y;
        for (int i = 0; i < W; i++) y[up_idx(i)] = x[i];
        return do_swaps(y, c);
    endfunction

    function automatic logic [W-1:0] ref_flip(logic [W-1:0] x, logic [H-1:0] c);
        logic [W-1:0] t = do_swaps(x, c);
        logic [W-1:0] y;
        for (int i = 0; i < W; i++) y[i] = t[up_idx(i)];
        return y;
    endfunction

    function automatic logic [W-1:0] ref_perm(logic [W-1:0] s, logic [W-1:0] c, logic [1:0] m);
        case (m)
            2'd0:    return ref_omega(ref_omega(s, c[H-1:0]), c[W-1:H]);
            2'd1:    return ref_flip(ref_omega(s, c[H-1:0]), c[W-1:H]);
            2'd2:    return ref_flip(ref_flip(s, c[H-1:0]), c[W-1:H]);
            default: return s;
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One accepted operation; sampled on the negedge after the capturing edge
    task automatic run_op(logic [W-1:0] s, logic [W-1:0] c, logic [1:0] m);
        @(negedge clk);
        src = s; ctrl = c; mode = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 out_valid", {63'd0, out_valid}, '0);
        check("R1 dst", dst, '0);
    endtask

    task automatic t_bypass;
        run_op(64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_AAAA_5555, 2'd3);
        check("R3 bypass a", dst, 64'h0123_4567_89AB_CDEF);
        check("R2 valid pulse", {63'd0, out_valid}, 64'd1);
        run_op(64'h8000_0000_0000_0001, '1, 2'd3);
        check("R3 bypass b", dst, 64'h8000_0000_0000_0001);
    endtask

    task automatic t_double_shuffle;
        // R4: bit i lands at rotl(rotl(i)); bit 1 -> 4, bit 32 -> 2
        run_op(64'h0000_0000_0000_0002, '0, 2'd0);
        check("R4 bit1", dst, 64'h0000_0000_0000_0010);
        run_op(64'h0000_0001_0000_0000, '0, 2'd0);
        check("R4 bit32", dst, 64'h0000_0000_0000_0004);
    endtask

    task automatic t_omega_stage;
        // R5/R7: only first stage swaps pair 0; bit 0 -> shuffle 0 -> swap 1 -> shuffle 2
        run_op(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'd0);
        check("R5 first omega swap", dst, 64'h0000_0000_0000_0004);
        // R7: high half drives second stage: bit 0 -> 0 -> 0 -> swap pair 0 -> 1
        run_op(64'h0000_0000_0000_0001, 64'h0000_0001_0000_0000, 2'd0);
        check("R7 high half second stage", dst, 64'h0000_0000_0000_0002);
    endtask

    task automatic t_cancel;
        run_op(64'hDEAD_BEEF_0BAD_F00D, '0, 2'd1);
        check("R9 identity", dst, 64'hDEAD_BEEF_0BAD_F00D);
        // R7 mode 1: low half on omega: bit 0 -> 0, swap -> 1, unshuffle -> 32
        run_op(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'd1);
        check("R7 mode1 low half", dst, 64'h0000_0001_0000_0000);
    endtask

    task automatic t_flip;
        // R10: bit 4 -> rotr twice -> 1
        run_op(64'h0000_0000_0000_0010, '0, 2'd2);
        check("R10 bit4", dst, 64'h0000_0000_0000_0002);
        // R6: swap pair 0 first: bit 0 -> 1 -> rotr -> 32 -> 16
        run_op(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'd2);
        check("R6 flip swap", dst, 64'h0000_0000_0001_0000);
    endtask

    task automatic t_mixed;
        logic [W-1:0] s = 64'h1357_9BDF_2468_ACE0;
        logic [W-1:0] c = 64'h0F1E_2D3C_4B5A_6978;
        for (int n = 0; n < 12; n++) begin
            logic [1:0] m = 2'(n % 3);
            logic [W-1:0] e = ref_perm(s, c, m);
            run_op(s, c, m);
            check("R5 R6 R7 model", dst, e);
            check("R8 ones", 64'($countones(dst)), 64'($countones(s)));
            s = {s[W-2:0], s[W-1] ^ s[W-2] ^ s[3]} ^ 64'h9E37_79B9_7F4A_7C15;
            c = {c[2:0], c[W-1:3]} ^ s;
        end
    endtask

    task automatic t_hold;
        logic [W-1:0] kept;
        run_op(64'hCAFE_F00D_1234_5678, 64'h5555_AAAA_3333_CCCC, 2'd1);
        kept = dst;
        @(negedge clk);
        src = '1; ctrl = '1; mode = 2'd0;
        repeat (3) @(negedge clk);
        check("R2 dst held", dst, kept);
        check("R2 no valid", {63'd0, out_valid}, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_double_shuffle();
        t_omega_stage();
        t_cancel();
        t_flip();
        t_mixed();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule